// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the host-facing entry to the configuration space of a multi-function peripheral controller. It watches byte reads and writes on a legacy I/O bus and answers at two neighbouring addresses: a selector port that chooses a register number, and a window port through which the chosen register is read or written. Until software writes a two-byte unlock key to the selector port, the whole interface is closed: window writes are dropped and every read returns 0xFF. Writing the lock key closes it again.

While open, register numbers below 0x30 are served locally by a small global bank: two read-only identity words, a device selector that tells the downstream banks which function is being programmed, and a soft-reset trigger. Register numbers at or above 0x30 are forwarded to the downstream per-function banks through a single-cycle strobe port carrying the register number and the data. The address pair is picked by a board strap captured during reset.

The key state machine has three states. ST_LOCKED moves to ST_HALF on a selector write of 0x87. ST_HALF moves to ST_OPEN on a second selector write of 0x87 and falls back to ST_LOCKED on any other selector write. ST_OPEN returns to ST_LOCKED on a selector write of 0xAA. Window accesses never move the state machine.

Top module: `cfg_port_ctrl`

## Requirements
- R1: With `strap_pri_pair` high during reset the selector port is at 0x004E and the window port at 0x004F; with it low they are 0x002E and 0x002F. The strap is captured only while `rst_n` is low and its later changes have no effect.
- R2: While closed (`cfg_open` low), window writes change nothing, no downstream strobe fires, and `bus_rdata` is 0xFF for every read. After reset the block is closed, `ldn_o` is 0x00 and `soft_rst_o` is 0.
- R3: The block opens only after two selector writes of 0x87 with no other selector write between them; window accesses between the two keys do not break the sequence, and any other selector write restarts it. `cfg_open` rises on the edge that takes the second key.
- R4: While open, a selector write of 0xAA closes the block on that edge and clears the register number to 0x00.
- R5: While open, any other selector write is stored as the register number, and a read of the selector port returns it in the same cycle.
- R6: Register 0x20 reads the high byte and 0x21 the low byte of the chip identity (default 0x5A31); 0x23 reads the high byte and 0x24 the low byte of the vendor identity (default 0x3C17). Writes to them change nothing.
- R7: Register 0x07 is the device selector: reset value 0x00, written through the window, read back through the window and driven on `ldn_o`.
- R8: A window write to register 0x02 with bit 0 set clears the device selector on that edge and raises `soft_rst_o` for exactly the following cycle, during which register 0x02 reads 0x01; at every other time it reads 0x00. A write with bit 0 clear has no effect, and the block stays open across a soft reset.
- R9: While open with a register number of 0x30 or more, a window write raises `dev_wr` and a window read raises `dev_rd` in the same cycle, with `dev_idx` equal to the register number and `dev_wdata` equal to the bus data; the read returns `dev_rdata`.
- R10: Register numbers below 0x30 other than 0x02, 0x07, 0x20, 0x21, 0x23 and 0x24 read 0x00 and ignore writes.
- R11: A read at any address other than the two active ports returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_pri_pair | input | 1 | Board strap: high selects 0x4E/0x4F, low selects 0x2E/0x2F |
| bus_addr | input | ADDR_W (16) | I/O address of the current access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| cfg_open | output | 1 | High while configuration access is unlocked |
| ldn_o | output | 8 | Current device selector value |
| soft_rst_o | output | 1 | One-cycle soft reset pulse to downstream banks |
| dev_wr | output | 1 | Write strobe to downstream banks |
| dev_rd | output | 1 | Read strobe to downstream banks |
| dev_idx | output | 8 | Register number for downstream access |
| dev_wdata | output | 8 | Write data for downstream access |
| dev_rdata | input | 8 | Read data from downstream banks |

## Verification
The soft-reset pulse and the key state machine can act in the same cycle: the bench writes the soft-reset bit and, in the very next cycle while `soft_rst_o` is high, writes the lock key 0xAA to the selector port. It then judges that the pulse was seen, that the block closed on that edge, that the pulse ended and the device selector stayed cleared. A second case stores a new register number during the pulse cycle and then writes the device selector, expecting the new value to stick, which shows the pulse does not mask a following write.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] REG_SRST   = 8'h02;
    localparam logic [7:0] REG_LDN    = 8'h07;
    localparam logic [7:0] REG_CHIP_H = 8'h20;
    localparam logic [7:0] REG_CHIP_L = 8'h21;
    localparam logic [7:0] REG_VEND_H = 8'h23;
    localparam logic [7:0] REG_VEND_L = 8'h24;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] PRI_BASE = 16'h004E,
    parameter logic [ADDR_W-1:0] ALT_BASE = 16'h002E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pri_pair,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit_sel,
    output logic              hit_win,
    output logic              use_alt
);

    localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] PRI_DATA = PRI_BASE + ONE;
    localparam logic [ADDR_W-1:0] ALT_DATA = ALT_BASE + ONE;

    logic use_alt_q;

    // strap captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_alt_q <= ~strap_pri_pair;
        end
    end

    always_comb begin
        hit_sel = use_alt_q ? (bus_addr == ALT_BASE) : (bus_addr == PRI_BASE);
        hit_win = use_alt_q ? (bus_addr == ALT_DATA) : (bus_addr == PRI_DATA);
    end

    assign use_alt = use_alt_q;

endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_port_pkg::*;
#(
    parameter logic [7:0] KEY_ENTER = 8'h87,
    parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [7:0] wdata,
    output logic       open
);

    key_state_e state_q;
    key_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (sel_wr && wdata == KEY_ENTER) state_d = ST_HALF;
            end
            ST_HALF: begin
                if (sel_wr) state_d = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
            end
            ST_OPEN: begin
                if (sel_wr && wdata == KEY_EXIT) state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        open = (state_q == ST_OPEN);
    end

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
    import cfg_port_pkg::*;
#(
    parameter logic [7:0]  KEY_EXIT  = 8'hAA,
    parameter logic [7:0]  DEV_BASE  = 8'h30,
    parameter logic [15:0] CHIP_ID   = 16'h5A31,
    parameter logic [15:0] VENDOR_ID = 16'h3C17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open,
    input  logic       sel_wr,
    input  logic       win_wr,
    input  logic       win_rd,
    input  logic [7:0] wdata,
    input  logic [7:0] dev_rdata,
    output logic [7:0] index,
    output logic [7:0] ldn,
    output logic       srst,
    output logic [7:0] reg_rdata,
    output logic       dev_wr,
    output logic       dev_rd
);

    logic [7:0] index_q;
    logic [7:0] ldn_q;
    logic       srst_q;
    logic       to_dev;
    logic       closing;
    logic       acc_wr;

    assign to_dev  = (index_q >= DEV_BASE);
    assign closing = open && sel_wr && (wdata == KEY_EXIT);
    assign acc_wr  = open && win_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            ldn_q   <= 8'h00;
            srst_q  <= 1'b0;
        end else begin
            srst_q <= 1'b0;
            if (closing) begin
                index_q <= 8'h00;
            end else if (open && sel_wr) begin
                index_q <= wdata;
            end
            if (acc_wr && !to_dev) begin
                if (index_q == REG_LDN) begin
                    ldn_q <= wdata;
                end else if (index_q == REG_SRST && wdata[0]) begin
                    ldn_q  <= 8'h00;
                    srst_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (to_dev) begin
            reg_rdata = dev_rdata;
        end else begin
            case (index_q)
                REG_SRST:   reg_rdata = {7'b0, srst_q};
                REG_LDN:    reg_rdata = ldn_q;
                REG_CHIP_H: reg_rdata = CHIP_ID[15:8];
                REG_CHIP_L: reg_rdata = CHIP_ID[7:0];
                REG_VEND_H: reg_rdata = VENDOR_ID[15:8];
                REG_VEND_L: reg_rdata = VENDOR_ID[7:0];
                default:    reg_rdata = 8'h00;
            endcase
        end
    end

    assign dev_wr = acc_wr && to_dev;
    assign dev_rd = open && win_rd && to_dev;
    assign index  = index_q;
    assign ldn    = ldn_q;
    assign srst   = srst_q;

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PRI_BASE  = 16'h004E,
    parameter logic [ADDR_W-1:0] ALT_BASE  = 16'h002E,
    parameter logic [7:0]        KEY_ENTER = 8'h87,
    parameter logic [7:0]        KEY_EXIT  = 8'hAA,
    parameter logic [7:0]        DEV_BASE  = 8'h30,
    parameter logic [15:0]       CHIP_ID   = 16'h5A31,
    parameter logic [15:0]       VENDOR_ID = 16'h3C17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pri_pair,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cfg_open,
    output logic [7:0]        ldn_o,
    output logic              soft_rst_o,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic [7:0]        dev_idx,
    output logic [7:0]        dev_wdata,
    input  logic [7:0]        dev_rdata
);

    logic       hit_sel;
    logic       hit_win;
    logic       use_alt;
    logic       open;
    logic [7:0] index;
    logic [7:0] reg_rdata;

    cfg_addr_decode #(
        .ADDR_W  (ADDR_W),
        .PRI_BASE(PRI_BASE),
        .ALT_BASE(ALT_BASE)
    ) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_pri_pair(strap_pri_pair),
        .bus_addr      (bus_addr),
        .hit_sel       (hit_sel),
        .hit_win       (hit_win),
        .use_alt       (use_alt)
    );

    cfg_key_fsm #(
        .KEY_ENTER(KEY_ENTER),
        .KEY_EXIT (KEY_EXIT)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_wr(bus_wr && hit_sel),
        .wdata (bus_wdata),
        .open  (open)
    );

    cfg_global_regs #(
        .KEY_EXIT (KEY_EXIT),
        .DEV_BASE (DEV_BASE),
        .CHIP_ID  (CHIP_ID),
        .VENDOR_ID(VENDOR_ID)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (open),
        .sel_wr   (bus_wr && hit_sel),
        .win_wr   (bus_wr && hit_win),
        .win_rd   (bus_rd && hit_win),
        .wdata    (bus_wdata),
        .dev_rdata(dev_rdata),
        .index    (index),
        .ldn      (ldn_o),
        .srst     (soft_rst_o),
        .reg_rdata(reg_rdata),
        .dev_wr   (dev_wr),
        .dev_rd   (dev_rd)
    );

    always_comb begin
        bus_rdata = 8'hFF;
        if (open && bus_rd) begin
            if (hit_sel)      bus_rdata = index;
            else if (hit_win) bus_rdata = reg_rdata;
        end
    end

    assign cfg_open  = open;
    assign dev_idx   = index;
    assign dev_wdata = bus_wdata;

endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
    parameter logic [7:0] KEY_ENTER = 8'h87,
    parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       cfg_open,
    input logic [7:0] ldn_o,
    input logic       soft_rst_o,
    input logic       dev_wr,
    input logic       dev_rd,
    input logic       use_alt
);

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(use_alt));

    // R2
    locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_rd) |-> (bus_rdata == 8'hFF));

    // R2
    locked_no_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> (!dev_wr && !dev_rd));

    // R3
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> ($past(bus_wr) && $past(bus_wdata) == KEY_ENTER));

    // R4
    close_needs_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_open) |-> ($past(bus_wr) && $past(bus_wdata) == KEY_EXIT));

    // R7
    ldn_locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(ldn_o));

    // R8
    srst_clears_ldn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (ldn_o == 8'h00 && cfg_open));

    // R8
    srst_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_o) |-> ($past(cfg_open) && $past(bus_wr) && $past(bus_wdata[0])));

endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
    .KEY_ENTER(KEY_ENTER),
    .KEY_EXIT (KEY_EXIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_open  (cfg_open),
    .ldn_o     (ldn_o),
    .soft_rst_o(soft_rst_o),
    .dev_wr    (dev_wr),
    .dev_rd    (dev_rd),
    .use_alt   (use_alt)
);

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;

    localparam logic [15:0] CHIP = 16'h5A31;
    localparam logic [15:0] VEND = 16'h3C17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_pri_pair = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        cfg_open;
    logic [7:0]  ldn_o;
    logic        soft_rst_o;
    logic        dev_wr;
    logic        dev_rd;
    logic [7:0]  dev_idx;
    logic [7:0]  dev_wdata;
    logic [7:0]  dev_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic       wr_dev_seen;
    logic [7:0] wr_idx_seen;
    logic [7:0] wr_dat_seen;
    logic       rd_dev_seen;
    logic [7:0] rv;

    always #5 clk = ~clk;

    assign dev_rdata = dev_idx ^ 8'h5C;

    cfg_port_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_pri_pair(strap_pri_pair),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .cfg_open      (cfg_open),
        .ldn_o         (ldn_o),
        .soft_rst_o    (soft_rst_o),
        .dev_wr        (dev_wr),
        .dev_rd        (dev_rd),
        .dev_idx       (dev_idx),
        .dev_wdata     (dev_wdata),
        .dev_rdata     (dev_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic bwr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        #2;
        wr_dev_seen = dev_wr;
        wr_idx_seen = dev_idx;
        wr_dat_seen = dev_wdata;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd = 1'b1;
        #2;
        d = bus_rdata;
        rd_dev_seen = dev_rd;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_pri_pair = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] exp_reg(input logic [7:0] idx, input logic [7:0] ldn);
        if (idx >= 8'h30) return idx ^ 8'h5C;
        case (idx)
            8'h07:   return ldn;
            8'h20:   return CHIP[15:8];
            8'h21:   return CHIP[7:0];
            8'h23:   return VEND[15:8];
            8'h24:   return VEND[7:0];
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        // R2 reset state and locked reads
        #1;
        chk("R2 open after reset", {7'b0, cfg_open}, 8'h00);
        chk("R2 ldn after reset", ldn_o, 8'h00);
        chk("R2 srst after reset", {7'b0, soft_rst_o}, 8'h00);
        @(negedge clk);
        brd(16'h004E, rv); chk("R2 locked sel read", rv, 8'hFF);
        brd(16'h004F, rv); chk("R2 locked win read", rv, 8'hFF);

        // R3 sweep of first key byte
        for (int v = 0; v < 256; v++) begin
            bwr(16'h004E, 8'(v));
            bwr(16'h004E, 8'h87);
            chk("R3 key sweep open", {7'b0, cfg_open}, (v == 8'h87) ? 8'h01 : 8'h00);
            if (cfg_open) begin
                bwr(16'h004E, 8'hAA);
                chk("R4 exit closes", {7'b0, cfg_open}, 8'h00);
            end else begin
                bwr(16'h004E, 8'h00);
                chk("R3 other byte resets", {7'b0, cfg_open}, 8'h00);
            end
        end

        // R3 window accesses between keys do not break sequence
        bwr(16'h004E, 8'h87);
        bwr(16'h004F, 8'h55);
        brd(16'h004F, rv);
        chk("R2 read between keys", rv, 8'hFF);
        bwr(16'h004E, 8'h87);
        chk("R3 open with window access between keys", {7'b0, cfg_open}, 8'h01);

        // R5 R6 R9 R10 index sweep with reads
        for (int v = 0; v < 256; v++) begin
            if (v != 8'hAA) begin
                bwr(16'h004E, 8'(v));
                brd(16'h004E, rv);
                chk("R5 index readback", rv, 8'(v));
                brd(16'h004F, rv);
                chk("R6 R9 R10 window read", rv, exp_reg(8'(v), 8'h00));
                chk("R9 dev_rd strobe", {7'b0, rd_dev_seen}, (v >= 8'h30) ? 8'h01 : 8'h00);
            end
        end

        // R7 device selector sweep
        bwr(16'h004E, 8'h07);
        for (int v = 0; v < 256; v++) begin
            bwr(16'h004F, 8'(v));
            chk("R7 no dev_wr for local reg", {7'b0, wr_dev_seen}, 8'h00);
            brd(16'h004F, rv);
            chk("R7 ldn readback", rv, 8'(v));
            chk("R7 ldn_o", ldn_o, 8'(v));
        end

        // R6 R10 writes ignored
        bwr(16'h004E, 8'h20); bwr(16'h004F, 8'h00);
        brd(16'h004F, rv); chk("R6 chip id read-only", rv, CHIP[15:8]);
        bwr(16'h004E, 8'h24); bwr(16'h004F, 8'hFF);
        brd(16'h004F, rv); chk("R6 vendor id read-only", rv, VEND[7:0]);
        bwr(16'h004E, 8'h10); bwr(16'h004F, 8'hFF);
        brd(16'h004F, rv); chk("R10 unused reg", rv, 8'h00);
        bwr(16'h004E, 8'h07);
        brd(16'h004F, rv); chk("R10 write elsewhere kept ldn", rv, 8'hFF);

        // R9 downstream write
        bwr(16'h004E, 8'h41);
        bwr(16'h004F, 8'h9C);
        chk("R9 dev_wr", {7'b0, wr_dev_seen}, 8'h01);
        chk("R9 dev_idx", wr_idx_seen, 8'h41);
        chk("R9 dev_wdata", wr_dat_seen, 8'h9C);

        // R8 soft reset
        bwr(16'h004E, 8'h07); bwr(16'h004F, 8'h5A);
        bwr(16'h004E, 8'h02); bwr(16'h004F, 8'hFE);
        #1;
        chk("R8 bit0 clear no pulse", {7'b0, soft_rst_o}, 8'h00);
        chk("R8 bit0 clear keeps ldn", ldn_o, 8'h5A);
        bwr(16'h004F, 8'h01);
        #1;
        chk("R8 pulse high", {7'b0, soft_rst_o}, 8'h01);
        chk("R8 ldn cleared", ldn_o, 8'h00);
        brd(16'h004F, rv);
        chk("R8 reg reads 01 in pulse", rv, 8'h01);
        #1;
        chk("R8 pulse one cycle", {7'b0, soft_rst_o}, 8'h00);
        brd(16'h004F, rv);
        chk("R8 reg reads 00 after", rv, 8'h00);
        chk("R8 stays open", {7'b0, cfg_open}, 8'h01);

        // R8 with R4 in the same cycle
        bwr(16'h004E, 8'h07); bwr(16'h004F, 8'h21);
        bwr(16'h004E, 8'h02); bwr(16'h004F, 8'h01);
        #1;
        chk("R8 pulse before exit", {7'b0, soft_rst_o}, 8'h01);
        bwr(16'h004E, 8'hAA);
        #1;
        chk("R4 exit during pulse closes", {7'b0, cfg_open}, 8'h00);
        chk("R8 pulse over after exit", {7'b0, soft_rst_o}, 8'h00);
        chk("R8 ldn stays cleared", ldn_o, 8'h00);

        // R2 locked writes ignored
        bwr(16'h004E, 8'h13);
        bwr(16'h004F, 8'h77);
        chk("R2 no dev_wr while locked", {7'b0, wr_dev_seen}, 8'h00);
        chk("R2 ldn unchanged while locked", ldn_o, 8'h00);
        brd(16'h004F, rv); chk("R2 locked window read", rv, 8'hFF);
        bwr(16'h004E, 8'h87); bwr(16'h004E, 8'h87);
        brd(16'h004E, rv); chk("R4 index cleared on exit", rv, 8'h00);

        // R8 index write in pulse cycle, then ldn write
        bwr(16'h004E, 8'h02); bwr(16'h004F, 8'h01);
        bwr(16'h004E, 8'h07);
        bwr(16'h004F, 8'h33);
        brd(16'h004F, rv); chk("R8 write after pulse sticks", rv, 8'h33);

        // R11 non-port addresses
        for (int a = 16'h004A; a < 16'h0054; a++) begin
            if (a != 16'h004E && a != 16'h004F) begin
                brd(16'(a), rv); chk("R11 other address", rv, 8'hFF);
            end
        end
        brd(16'h002E, rv); chk("R11 alt pair inactive", rv, 8'hFF);

        // R1 alternate pair
        do_reset(1'b0);
        @(negedge clk);
        strap_pri_pair = 1'b1;
        bwr(16'h004E, 8'h87); bwr(16'h004E, 8'h87);
        chk("R1 primary pair dead", {7'b0, cfg_open}, 8'h00);
        bwr(16'h002E, 8'h87); bwr(16'h002E, 8'h87);
        chk("R1 alt pair opens", {7'b0, cfg_open}, 8'h01);
        bwr(16'h002E, 8'h21);
        brd(16'h002F, rv); chk("R1 alt window read", rv, CHIP[7:0]);
        brd(16'h004F, rv); chk("R1 R11 primary window dead", rv, 8'hFF);
        brd(16'h002E, rv); chk("R1 strap change ignored", rv, 8'h21);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule